// File: doc/BRIEF.md
# Sequencer Program Memory Access Port

This block holds the program of a row-timing sequencer in a small byte-wide memory and gives a host two register-mapped ways to reach it. The host selects an access mode by writing a 16-bit key to a control register. The same write rewinds an internal byte pointer to the first program byte. After that, the host streams through one data register. In load mode, each 16-bit write deposits two consecutive program bytes. In read-back mode, each 8-bit read returns the next single byte. Both directions step the same auto-incrementing pointer.

Program length sets how long the sequencer spends on each row, so a shorter program gives faster frames. For that reason the memory can be rewritten in the field, but only while the sensor sits in standby. Outside standby, the host data port refuses all traffic. A separate read-only fetch port then serves the sequencer engine, which addresses program bytes directly.

Host accesses are single-cycle strobes. Each strobe carries an address, a size bit (1 = 16-bit, 0 = 8-bit), a write flag and write data. Read data appears on the cycle after the strobe and is zero on every other cycle. The memory is split into an even-byte bank and an odd-byte bank, so that one 16-bit write stores both bytes in a single cycle.

Top module: `seqram_port`

## Requirements
- R1: After reset the mode is idle, `seq_ovf` is 0, `reg_rdata` is 0, and a control-register read returns 0x0000.
- R2: A write of 0x8000 to the control register (address 0x0010) selects load mode, sets the pointer to byte 0 and clears `seq_ovf`; a control read then returns 0x8000.
- R3: A write of 0xC000 to the control register selects read-back mode, sets the pointer to byte 0 and clears `seq_ovf`; a control read then returns 0xC000.
- R4: A control write of any other value selects idle mode and leaves the pointer alone. A control read then returns 0x0000. In idle mode, data-register writes change no byte and data-register reads return 0.
- R5: In load mode with standby high, a 16-bit write to the data register (address 0x0012) stores bits 15:8 at byte N and bits 7:0 at byte N+1, where N is the pointer. The bytes are stored exactly as written, so a zero pad byte is stored as zero. The pointer then advances by 2.
- R6: In read-back mode with standby high, an 8-bit read of the data register returns {8'h00, byte N} on the next cycle, and the pointer advances by 1.
- R7: With standby low, data-register writes are ignored, data-register reads return 0, and the pointer does not move.
- R8: A data-register access of the wrong size (an 8-bit write in load mode, or a 16-bit read in read-back mode) stores nothing, returns 0 and does not move the pointer.
- R9: The pointer wraps from the last byte (DEPTH-1, default 511) back to byte 0.
- R10: `seq_ovf` becomes 1 when a load write arrives after the pointer has wrapped past the last byte. That write is stored at the wrapped address. The flag stays at 1 until reset or a 0x8000/0xC000 control write.
- R11: The fetch port returns, one cycle after the request, the byte at `fetch_addr` when standby is low, and returns 0 when standby is high.
- R12: Reads of any register address other than the control and data registers return 0, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | High while the sensor is in standby; gates host data access |
| reg_stb | input | 1 | Single-cycle register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| fetch_addr | input | 9 | Engine fetch byte address |
| fetch_data | output | 8 | Engine fetch byte, one cycle after the address |
| seq_ovf | output | 1 | Sticky load-overflow flag |

## Verification
The bench targets the following corner cases:
- Byte order inside a packed write. A swapped packing would read back as reversed pairs.
- A zero pad byte in an odd-length program. It must come back as zero.
- The pointer across accesses that are refused, whether for lack of standby, wrong size or idle mode. A design that stepped on a refused access would shift every later byte.
- A full 512-byte fill followed by one extra write. A design that flagged the exact fill, or lost the extra write, would show a wrong `seq_ovf` or a wrong byte 0 after wrap.
- Fetches made while standby flips. A design that let a fetch leak during programming would return non-zero bytes.

// File: rtl/seqram_pkg.sv
package seqram_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_LOAD = 2'd1,
    MODE_READ = 2'd2
  } seq_mode_e;

  localparam logic [15:0] KEY_LOAD = 16'h8000;
  localparam logic [15:0] KEY_READ = 16'hC000;

  function automatic logic [15:0] mode_code(input seq_mode_e m);
    case (m)
      MODE_LOAD: mode_code = KEY_LOAD;
      MODE_READ: mode_code = KEY_READ;
      default:   mode_code = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/seqram_bank.sv
module seqram_bank #(
  parameter int ROWS = 256,
  parameter int DW   = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [RW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_q,
  input  logic [RW-1:0] b_addr,
  output logic [DW-1:0] b_q
);

  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_addr] <= a_wdata;
    end
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end

endmodule

// File: rtl/seqram_ctrl.sv
module seqram_ctrl
  import seqram_pkg::*;
#(
  parameter int          DEPTH     = 512,
  parameter int          REG_AW    = 16,
  parameter logic [15:0] CTRL_ADDR = 16'h0010,
  parameter logic [15:0] DATA_ADDR = 16'h0012,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         RW        = AW - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              reg_stb,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic              host_we,
  output logic [RW-1:0]     host_row,
  output logic [7:0]        host_wd_even,
  output logic [7:0]        host_wd_odd,
  output logic              data_rd_q,
  output logic              rd_odd_q,
  output logic              ctrl_rd_q,
  output logic [15:0]       ctrl_val_q,
  output logic              seq_ovf
);

  localparam logic [AW-1:0] LAST_PAIR = AW'(DEPTH - 2);

  seq_mode_e       mode;
  logic [AW-1:0]   ptr;
  logic            wrapped;

  logic hit_ctrl, hit_data, ctrl_wr, load_ok, read_ok;

  always_comb begin
    hit_ctrl = reg_stb && (reg_addr == REG_AW'(CTRL_ADDR));
    hit_data = reg_stb && (reg_addr == REG_AW'(DATA_ADDR));
    ctrl_wr  = hit_ctrl && reg_we;
    load_ok  = hit_data && reg_we && reg_wide && standby && (mode == MODE_LOAD);
    read_ok  = hit_data && !reg_we && !reg_wide && standby && (mode == MODE_READ);
  end

  assign host_we      = load_ok;
  assign host_row     = ptr[AW-1:1];
  assign host_wd_even = reg_wdata[15:8];
  assign host_wd_odd  = reg_wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_IDLE;
      ptr        <= '0;
      wrapped    <= 1'b0;
      seq_ovf    <= 1'b0;
      data_rd_q  <= 1'b0;
      rd_odd_q   <= 1'b0;
      ctrl_rd_q  <= 1'b0;
      ctrl_val_q <= 16'h0000;
    end else begin
      data_rd_q  <= read_ok;
      rd_odd_q   <= ptr[0];
      ctrl_rd_q  <= hit_ctrl && !reg_we;
      ctrl_val_q <= mode_code(mode);
      if (ctrl_wr) begin
        case (reg_wdata)
          KEY_LOAD: begin
            mode    <= MODE_LOAD;
            ptr     <= '0;
            wrapped <= 1'b0;
            seq_ovf <= 1'b0;
          end
          KEY_READ: begin
            mode    <= MODE_READ;
            ptr     <= '0;
            wrapped <= 1'b0;
            seq_ovf <= 1'b0;
          end
          default: mode <= MODE_IDLE;
        endcase
      end else if (load_ok) begin
        ptr <= ptr + AW'(2);
        if (ptr == LAST_PAIR) begin
          wrapped <= 1'b1;
        end
        if (wrapped) begin
          seq_ovf <= 1'b1;
        end
      end else if (read_ok) begin
        ptr <= ptr + AW'(1);
      end
    end
  end

endmodule

// File: rtl/seqram_port.sv
module seqram_port #(
  parameter int          DEPTH     = 512,
  parameter int          REG_AW    = 16,
  parameter logic [15:0] CTRL_ADDR = 16'h0010,
  parameter logic [15:0] DATA_ADDR = 16'h0012,
  localparam int         AW        = $clog2(DEPTH),
  localparam int         RW        = AW - 1,
  localparam int         ROWS      = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              reg_stb,
  input  logic              reg_we,
  input  logic              reg_wide,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [AW-1:0]     fetch_addr,
  output logic [7:0]        fetch_data,
  output logic              seq_ovf
);

  logic          host_we;
  logic [RW-1:0] host_row;
  logic [7:0]    wd [2];
  logic [7:0]    host_q [2];
  logic [7:0]    fetch_q [2];
  logic          data_rd_q, rd_odd_q, ctrl_rd_q;
  logic [15:0]   ctrl_val_q;
  logic          fetch_odd_q, fetch_block_q;

  seqram_ctrl #(
    .DEPTH(DEPTH), .REG_AW(REG_AW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .standby(standby),
    .reg_stb(reg_stb), .reg_we(reg_we), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .host_we(host_we), .host_row(host_row),
    .host_wd_even(wd[0]), .host_wd_odd(wd[1]),
    .data_rd_q(data_rd_q), .rd_odd_q(rd_odd_q),
    .ctrl_rd_q(ctrl_rd_q), .ctrl_val_q(ctrl_val_q),
    .seq_ovf(seq_ovf)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    seqram_bank #(.ROWS(ROWS), .DW(8)) u_bank (
      .clk(clk),
      .a_we(host_we), .a_addr(host_row), .a_wdata(wd[g]), .a_q(host_q[g]),
      .b_addr(fetch_addr[AW-1:1]), .b_q(fetch_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_odd_q   <= 1'b0;
      fetch_block_q <= 1'b1;
    end else begin
      fetch_odd_q   <= fetch_addr[0];
      fetch_block_q <= standby;
    end
  end

  always_comb begin
    if (ctrl_rd_q) begin
      reg_rdata = ctrl_val_q;
    end else if (data_rd_q) begin
      reg_rdata = {8'h00, host_q[rd_odd_q]};
    end else begin
      reg_rdata = 16'h0000;
    end
    fetch_data = fetch_block_q ? 8'h00 : fetch_q[fetch_odd_q];
  end

endmodule

// File: rtl/seqram_port_chk.sv
module seqram_port_chk #(
  parameter int          REG_AW    = 16,
  parameter logic [15:0] CTRL_ADDR = 16'h0010,
  parameter logic [15:0] DATA_ADDR = 16'h0012
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic              reg_stb,
  input logic              reg_we,
  input logic              reg_wide,
  input logic [REG_AW-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic [7:0]        fetch_data,
  input logic              seq_ovf
);

  logic to_ctrl, to_data, mode_key;
  assign to_ctrl  = reg_stb && (reg_addr == REG_AW'(CTRL_ADDR));
  assign to_data  = reg_stb && (reg_addr == REG_AW'(DATA_ADDR));
  assign mode_key = to_ctrl && reg_we && (reg_wdata == 16'h8000 || reg_wdata == 16'hC000);

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (!seq_ovf && reg_rdata == 16'h0000));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (seq_ovf && !mode_key) |=> seq_ovf);

  assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_ovf) |-> $past(to_data && reg_we && reg_wide && standby));

  assert_no_standby_read_R7: assert property (@(posedge clk) disable iff (rst)
    (to_data && !reg_we && !standby) |=> (reg_rdata == 16'h0000));

  assert_wide_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (to_data && !reg_we && reg_wide) |=> (reg_rdata == 16'h0000));

  assert_fetch_blocked_R11: assert property (@(posedge clk) disable iff (rst)
    standby |=> (fetch_data == 8'h00));

  assert_other_addr_R12: assert property (@(posedge clk) disable iff (rst)
    (reg_stb && !reg_we && !to_ctrl && !to_data) |=> (reg_rdata == 16'h0000));

endmodule

bind seqram_port seqram_port_chk #(
  .REG_AW(REG_AW), .CTRL_ADDR(CTRL_ADDR), .DATA_ADDR(DATA_ADDR)
) i_chk (
  .clk(clk), .rst(rst), .standby(standby), .reg_stb(reg_stb), .reg_we(reg_we),
  .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .fetch_data(fetch_data), .seq_ovf(seq_ovf)
);

// File: tb/test_seqram_port.sv
module test_seqram_port;

  localparam int N = 512;
  localparam logic [15:0] CA = 16'h0010;
  localparam logic [15:0] DA = 16'h0012;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b1;
  logic        reg_stb = 1'b0, reg_we = 1'b0, reg_wide = 1'b0;
  logic [15:0] reg_addr = 16'h0, reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic [8:0]  fetch_addr = 9'h0;
  logic [7:0]  fetch_data;
  logic        seq_ovf;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  seqram_port i_seqram_port (
    .clk(clk), .rst(rst), .standby(standby), .reg_stb(reg_stb), .reg_we(reg_we),
    .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .seq_ovf(seq_ovf)
  );

  // Behavioural reference model
  int m_mem [N];
  int m_mode = 0;            // 0 idle, 1 load, 2 read
  int m_ptr = 0;
  bit m_wrapped = 0, m_ovf = 0;
  int exp_rdata = 0, exp_fetch = 0;   // -1 = unknown

  initial foreach (m_mem[i]) m_mem[i] = -1;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_ptr = 0; m_wrapped = 0; m_ovf = 0;
      exp_rdata = 0; exp_fetch = 0;
    end else begin
      exp_fetch = standby ? 0 : m_mem[fetch_addr];
      exp_rdata = 0;
      if (reg_stb && !reg_we && reg_addr == CA)
        exp_rdata = (m_mode == 1) ? 32'h8000 : (m_mode == 2) ? 32'hC000 : 0;
      else if (reg_stb && !reg_we && reg_addr == DA && !reg_wide && standby && m_mode == 2)
        exp_rdata = m_mem[m_ptr];
      if (reg_stb && reg_we && reg_addr == CA) begin
        if (reg_wdata == 16'h8000 || reg_wdata == 16'hC000) begin
          m_mode = (reg_wdata == 16'h8000) ? 1 : 2;
          m_ptr = 0; m_wrapped = 0; m_ovf = 0;
        end else m_mode = 0;
      end else if (reg_stb && reg_we && reg_addr == DA && reg_wide && standby && m_mode == 1) begin
        m_mem[m_ptr]     = int'(reg_wdata[15:8]);
        m_mem[m_ptr + 1] = int'(reg_wdata[7:0]);
        if (m_wrapped) m_ovf = 1;
        if (m_ptr == N - 2) m_wrapped = 1;
        m_ptr = (m_ptr + 2) % N;
      end else if (reg_stb && !reg_we && reg_addr == DA && !reg_wide && standby && m_mode == 2) begin
        m_ptr = (m_ptr + 1) % N;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_rdata >= 0) begin
        checks++;
        if (int'(reg_rdata) != exp_rdata) begin
          errors++;
          $display("FAIL %s rdata actual %h expected %h", cur_req, reg_rdata, exp_rdata);
        end
      end
      checks++;
      if (seq_ovf != m_ovf) begin
        errors++;
        $display("FAIL %s seq_ovf actual %0d expected %0d", cur_req, seq_ovf, m_ovf);
      end
      if (exp_fetch >= 0) begin
        checks++;
        if (int'(fetch_data) != exp_fetch) begin
          errors++;
          $display("FAIL %s fetch_data actual %h expected %h", cur_req, fetch_data, exp_fetch);
        end
      end
    end
  end

  task automatic acc(input logic we, input logic wide, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_stb = 1'b1; reg_we = we; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_stb = 1'b0; reg_we = 1'b0; reg_wide = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [15:0] e);
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s directed rdata actual %h expected %h", req, reg_rdata, e);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    cur_req = "R1";
    acc(0, 1, CA, 0); expect_rd("R1", 16'h0000);

    cur_req = "R2";
    acc(1, 1, CA, 16'h8000);
    acc(0, 1, CA, 0); expect_rd("R2", 16'h8000);
    cur_req = "R5";
    acc(1, 1, DA, 16'h1234);
    acc(1, 1, DA, 16'hA5B6);
    acc(1, 1, DA, 16'h7700);

    cur_req = "R3";
    acc(1, 1, CA, 16'hC000);
    acc(0, 1, CA, 0); expect_rd("R3", 16'hC000);
    cur_req = "R6";
    acc(0, 0, DA, 0); expect_rd("R6", 16'h0012);
    acc(0, 0, DA, 0); expect_rd("R5", 16'h0034);
    cur_req = "R8";
    acc(0, 1, DA, 0); expect_rd("R8", 16'h0000);
    cur_req = "R7";
    standby = 1'b0;
    acc(0, 0, DA, 0); expect_rd("R7", 16'h0000);
    standby = 1'b1;
    cur_req = "R6";
    acc(0, 0, DA, 0); expect_rd("R8", 16'h00A5);
    acc(0, 0, DA, 0); expect_rd("R6", 16'h00B6);
    acc(0, 0, DA, 0); expect_rd("R6", 16'h0077);
    acc(0, 0, DA, 0); expect_rd("R5", 16'h0000);

    cur_req = "R11";
    standby = 1'b0;
    @(negedge clk); fetch_addr = 9'd3;
    @(negedge clk); @(negedge clk);
    checks++;
    if (fetch_data !== 8'hB6) begin
      errors++; $display("FAIL R11 fetch actual %h expected b6", fetch_data);
    end
    standby = 1'b1;
    @(negedge clk); @(negedge clk);
    checks++;
    if (fetch_data !== 8'h00) begin
      errors++; $display("FAIL R11 fetch in standby actual %h expected 00", fetch_data);
    end

    cur_req = "R7";
    acc(1, 1, CA, 16'h8000);
    standby = 1'b0;
    acc(1, 1, DA, 16'hFFFF);
    standby = 1'b1;
    cur_req = "R8";
    acc(1, 0, DA, 16'hEEEE);
    acc(1, 1, DA, 16'h1111);
    acc(1, 1, CA, 16'hC000);
    acc(0, 0, DA, 0); expect_rd("R7", 16'h0011);
    acc(0, 0, DA, 0); expect_rd("R8", 16'h0011);
    acc(0, 0, DA, 0); expect_rd("R7", 16'h00A5);

    cur_req = "R4";
    acc(1, 1, CA, 16'h1234);
    acc(0, 1, CA, 0); expect_rd("R4", 16'h0000);
    acc(0, 0, DA, 0); expect_rd("R4", 16'h0000);
    acc(1, 1, DA, 16'h9999);
    cur_req = "R12";
    acc(1, 1, 16'h0014, 16'h8000);
    acc(0, 1, 16'h0014, 0); expect_rd("R12", 16'h0000);
    acc(1, 1, CA, 16'hC000);
    acc(0, 0, DA, 0); expect_rd("R4", 16'h0011);

    cur_req = "R10";
    acc(1, 1, CA, 16'h8000);
    for (int i = 0; i < N / 2; i++) acc(1, 1, DA, {i[7:0], ~i[7:0]});
    checks++;
    if (seq_ovf !== 1'b0) begin
      errors++; $display("FAIL R10 exact fill actual %0d expected 0", seq_ovf);
    end
    acc(1, 1, DA, 16'hDEAD);
    checks++;
    if (seq_ovf !== 1'b1) begin
      errors++; $display("FAIL R10 overflow actual %0d expected 1", seq_ovf);
    end
    acc(1, 1, CA, 16'h0001);
    checks++;
    if (seq_ovf !== 1'b1) begin
      errors++; $display("FAIL R10 sticky actual %0d expected 1", seq_ovf);
    end
    acc(1, 1, CA, 16'hC000);
    cur_req = "R9";
    acc(0, 0, DA, 0); expect_rd("R10", 16'h00DE);
    acc(0, 0, DA, 0); expect_rd("R10", 16'h00AD);
    for (int i = 2; i < N; i++) acc(0, 0, DA, 0);
    acc(0, 0, DA, 0); expect_rd("R9", 16'h00DE);
    acc(0, 0, DA, 0); expect_rd("R9", 16'h00AD);
    acc(0, 0, DA, 0); expect_rd("R9", 16'h0001);

    cur_req = "R11";
    standby = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); fetch_addr = 9'(i * 13);
      if (i == 20) standby = 1'b1;
      if (i == 30) standby = 1'b0;
    end
    @(negedge clk); @(negedge clk);
    finish_run();
  end

endmodule